// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block drives the strobe pins of a NAND flash device for single byte transfers. A requester offers either a write carrying one data byte or a read, using a valid/ready handshake. The block then runs chip enable, write enable or read enable, and the data-bus output enable through a timed sequence. The low and high phases, the chip-enable lead before a read, the bus turnaround and the ready/busy ignore window all come from one packed 32-bit timing word. Every interval is a whole number of system clock cycles.

The length of each high phase is given as the difference between its high field and its low field. If that difference is not positive, the high phase lasts one cycle. A read returns the byte sampled on the last clock of the read-enable low phase. Once an operation has finished, the block shows the device's ready/busy line as a busy flag. During the window just after each strobe rises, it ignores that line.

Top module: `nand_strobe_seq`

## Requirements
- R1: While reset is held and right after it: chip enable, write enable and read enable are high (inactive), the output enable is low, req_ready is high, busy is low and rd_valid is low.
- R2: Timing word fields. Bits 3:0 are the write low count WL and bits 7:4 are the write high count WH. Bits 11:8 are the read low count RL and bits 15:12 are the read high count RH. Bits 18:16 are the turnaround TA, bits 23:19 are the busy-ignore count BD, and bits 25:24 are the chip-enable lead CD. Bits 31:26 are unused.
- R3: A write drives write enable low for WL+1 cycles, starting in the cycle after acceptance. Chip enable is low and the output enable is high during this phase, and nand_dq_out carries the accepted byte.
- R4: After write enable rises, chip enable stays low and the output enable stays high for max(WH−WL,1) cycles. Both then go inactive.
- R5: For a read, chip enable goes low in the cycle after acceptance and stays low for CD cycles before read enable falls. When CD=0, read enable falls in that same first cycle. The output enable stays low for the whole read.
- R6: Read enable stays low for RL+1 cycles. After it rises, chip enable stays low for max(RH−RL,1) more cycles.
- R7: rd_data takes the value of nand_dq_in at the clock edge that ends the read-enable low phase. rd_valid is high for exactly one cycle, the first cycle after read enable rises.
- R8: After a strobe rises, req_ready stays low for a recovery of max(H+T, BD) cycles and then returns high. H is the high-phase length from R4 or R6. T is TA for a read and 0 for a write.
- R9: busy stays low from acceptance until the recovery ends, whatever nand_rdy_bsy does. Once an operation has completed, busy equals the inverse of nand_rdy_bsy, where low means the device is busy.
- R10: The timing word and write byte are captured at acceptance. Changing them during an operation has no effect on that operation.
- R11: Write enable and read enable are never low together. The output enable is only high while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_cfg | input | 32 | Packed timing word (R2) |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Block idle and accepting |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rdy_bsy | input | 1 | Device ready (1) / busy (0) |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Captured read byte |
| busy | output | 1 | Device busy after the last operation |

## Verification
Random timing words are mixed with reads and writes. Because the words vary, the low, high and lead phases show up as separate counts, so an off-by-one in any one phase stands out. Directed words target specific corner cases: all zeros gives the shortest strobe, all ones gives the longest, a high field below its low field exercises the one-cycle clamp, and words where BD dominates or where TA dominates show which term sets the recovery length. The read bus carries the wrong byte on every low cycle except the last, so a capture on the wrong edge is visible. The timing word and ready/busy input are changed during each operation to show that both are ignored.

// File: rtl/nand_seq_pkg.sv
// Shared types for the NAND strobe sequencer: phase-length bundle and state codes.
package nand_seq_pkg;
    localparam int CNT_W = 6;

    // Per-operation phase lengths, in clock cycles.
    typedef struct packed {
        logic [CNT_W-1:0] lead;   // chip enable low before strobe falls
        logic [CNT_W-1:0] low;    // strobe low length
        logic [CNT_W-1:0] hold;   // chip enable held after strobe rises
        logic [CNT_W-1:0] tail;   // total recovery after strobe rises
    } phase_lens_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LEAD    = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } seq_state_t;
endpackage

// File: rtl/nand_cfg_decode.sv
// Turns the packed timing word into phase lengths for one direction.
// Assumes: the high phase is clamped to one cycle when its field is not
// above the low field; the recovery covers both turnaround and busy ignore.
module nand_cfg_decode
    import nand_seq_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [CFG_W-1:0] cfg,
    input  logic             is_write,
    output phase_lens_t      lens
);
    localparam int WL_LSB = 0;
    localparam int WH_LSB = 4;
    localparam int RL_LSB = 8;
    localparam int RH_LSB = 12;
    localparam int TA_LSB = 16;
    localparam int BD_LSB = 19;
    localparam int CD_LSB = 24;

    logic [3:0]       lo_f, hi_f;
    logic [2:0]       ta_f;
    logic [4:0]       bd_f;
    logic [1:0]       cd_f;
    logic [CNT_W-1:0] hold_v, turn_v;

    // Pick the direction's fields and derive each phase length.
    always_comb begin
        lo_f   = is_write ? cfg[WL_LSB +: 4] : cfg[RL_LSB +: 4];
        hi_f   = is_write ? cfg[WH_LSB +: 4] : cfg[RH_LSB +: 4];
        ta_f   = is_write ? 3'd0 : cfg[TA_LSB +: 3];
        bd_f   = cfg[BD_LSB +: 5];
        cd_f   = is_write ? 2'd0 : cfg[CD_LSB +: 2];
        hold_v = (hi_f > lo_f) ? CNT_W'(hi_f - lo_f) : CNT_W'(1);
        turn_v = hold_v + CNT_W'(ta_f);
        lens.lead = CNT_W'(cd_f);
        lens.low  = CNT_W'(lo_f) + CNT_W'(1);
        lens.hold = hold_v;
        lens.tail = (turn_v > CNT_W'(bd_f)) ? turn_v : CNT_W'(bd_f);
    end
endmodule

// File: rtl/nand_phase_ctrl.sv
// Phase state machine: lead, strobe low, recovery; drives the strobes and
// captures read data. Assumes phase lengths are snapshotted at acceptance.
module nand_phase_ctrl
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_lens_t       lens_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic              accept,
    output logic              op_done,
    output logic              idle,
    output logic              ce_n,
    output logic              we_n,
    output logic              re_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    seq_state_t       state;
    phase_lens_t      lens_q;
    logic             wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [CNT_W-1:0] cnt;
    logic             in_hold;

    // Handshake and phase-end decodes.
    always_comb begin
        idle    = (state == ST_IDLE);
        accept  = idle && req_valid;
        in_hold = (state == ST_RECOVER) && (cnt < lens_q.hold);
        op_done = (state == ST_RECOVER) && (cnt == lens_q.tail - CNT_W'(1));
    end

    // Advance through the phases, counting cycles in each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            lens_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    lens_q  <= lens_in;
                    wr_q    <= req_write;
                    wdata_q <= req_wdata;
                    cnt     <= '0;
                    state   <= (lens_in.lead != '0) ? ST_LEAD : ST_STROBE;
                end
                ST_LEAD: if (cnt == lens_q.lead - CNT_W'(1)) begin
                    cnt   <= '0;
                    state <= ST_STROBE;
                end else cnt <= cnt + CNT_W'(1);
                ST_STROBE: if (cnt == lens_q.low - CNT_W'(1)) begin
                    cnt   <= '0;
                    state <= ST_RECOVER;
                end else cnt <= cnt + CNT_W'(1);
                default: if (op_done) state <= ST_IDLE;
                         else cnt <= cnt + CNT_W'(1);
            endcase
        end
    end

    // Capture the read byte on the edge that ends the read low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (state == ST_STROBE && !wr_q && cnt == lens_q.low - CNT_W'(1)) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
            end
        end
    end

    // Strobe pin decode from the current phase.
    always_comb begin
        ce_n   = !(state == ST_LEAD || state == ST_STROBE || in_hold);
        we_n   = !(state == ST_STROBE && wr_q);
        re_n   = !(state == ST_STROBE && !wr_q);
        dq_oe  = wr_q && (state == ST_STROBE || in_hold);
        dq_out = wdata_q;
    end

    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    assert_oe_under_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !ce_n);
    assert_rdvalid_after_re_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (re_n && !$past(re_n)));
    assert_write_data_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(dq_out));
    assert_no_accept_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !idle);
endmodule

// File: rtl/nand_busy_track.sv
// Reports device busy once an operation has fully completed.
// Assumes ready/busy is meaningless from acceptance to the end of recovery.
module nand_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic op_done,
    input  logic idle,
    input  logic rdy_bsy,
    output logic busy
);
    logic armed;

    // Arm after completion, disarm when the next operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (accept)  armed <= 1'b0;
        else if (op_done) armed <= 1'b1;
    end

    // Busy flag follows the pin only while armed.
    always_comb busy = armed && !rdy_bsy;

    assert_busy_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idle);
    assert_arm_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(op_done));
endmodule

// File: rtl/nand_strobe_seq.sv
// Top of the NAND strobe sequencer: timing decode, phase control, busy report.
// Assumes one transfer at a time; timing word sampled at acceptance.
module nand_strobe_seq
    import nand_seq_pkg::*;
#(
    parameter int CFG_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  timing_cfg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              nand_ce_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_dq_oe,
    output logic [DATA_W-1:0] nand_dq_out,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rdy_bsy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    phase_lens_t lens;
    logic        accept, op_done, idle;

    nand_cfg_decode #(.CFG_W(CFG_W)) i_decode (
        .cfg      (timing_cfg),
        .is_write (req_write),
        .lens     (lens)
    );

    nand_phase_ctrl #(.DATA_W(DATA_W)) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .lens_in   (lens),
        .dq_in     (nand_dq_in),
        .accept    (accept),
        .op_done   (op_done),
        .idle      (idle),
        .ce_n      (nand_ce_n),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .dq_oe     (nand_dq_oe),
        .dq_out    (nand_dq_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    nand_busy_track i_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .op_done (op_done),
        .idle    (idle),
        .rdy_bsy (nand_rdy_bsy),
        .busy    (busy)
    );

    // Ready mirrors the idle phase.
    always_comb req_ready = idle;
endmodule

// File: tb/test_nand_strobe_seq.sv
module test_nand_strobe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_cfg = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_wdata = '0, nand_dq_in = '0, nand_dq_out, rd_data;
    logic        req_ready, nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe;
    logic        nand_rdy_bsy = 1'b1, rd_valid, busy;
    int total = 0, bad = 0, cycles = 0;

    always #2.5 clk = ~clk;

    nand_strobe_seq i_nand_strobe_seq (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected lengths from the R2 field layout.
    function automatic int e_low(input logic [31:0] c, input bit wr);
        return (wr ? int'(c[3:0]) : int'(c[11:8])) + 1;
    endfunction
    function automatic int e_hold(input logic [31:0] c, input bit wr);
        int lo = wr ? int'(c[3:0]) : int'(c[11:8]);
        int hi = wr ? int'(c[7:4]) : int'(c[15:12]);
        return (hi > lo) ? hi - lo : 1;
    endfunction
    function automatic int e_tail(input logic [31:0] c, input bit wr);
        int t = e_hold(c, wr) + (wr ? 0 : int'(c[18:16]));
        int b = int'(c[23:19]);
        return (t > b) ? t : b;
    endfunction

    task automatic run_op(input bit wr, input logic [31:0] cfg, input logic [7:0] d);
        int lead = 0, low = 0, hold = 0, tail = 0, guard = 0;
        int rv_cnt = 0, rv_good = 0, bad_oe = 0, bad_busy = 0, bad_pre = 0;
        int erl = e_low(cfg, 1'b0) - 1;
        @(negedge clk);
        timing_cfg = cfg; req_write = wr; req_wdata = d; req_valid = 1'b1;
        nand_dq_in = ~d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        timing_cfg = $urandom;    // R10: must not disturb this operation
        req_wdata = 8'($urandom);
        while (!req_ready && guard < 200) begin
            if (busy) bad_busy++;
            if (!nand_we_n || !nand_re_n) begin
                low++;
                if (wr && (!nand_dq_oe || nand_dq_out != d || nand_ce_n)) bad_oe++;
                if (!wr && (nand_dq_oe || !nand_we_n)) bad_oe++;
                if (!wr) nand_dq_in = (low - 1 == erl) ? d : ~d;
            end else if (low == 0) begin
                if (!nand_ce_n) lead++;
                if (nand_dq_oe) bad_pre++;
            end else begin
                tail++;
                if (!nand_ce_n) hold++;
                if (wr && (nand_dq_oe != !nand_ce_n)) bad_oe++;
                if (!wr && nand_dq_oe) bad_oe++;
                if (rd_valid) begin
                    rv_cnt++;
                    if (tail == 1 && rd_data == d) rv_good++;
                end
            end
            nand_rdy_bsy = 1'($urandom);
            @(negedge clk);
            guard++;
        end
        if (wr) begin
            chk(lead == 0 && bad_pre == 0, "R3 no lead on write", lead, 0);
            chk(low == e_low(cfg, 1'b1), "R3 write low length (R2 fields)", low, e_low(cfg, 1'b1));
            chk(hold == e_hold(cfg, 1'b1), "R4 write hold", hold, e_hold(cfg, 1'b1));
            chk(bad_oe == 0, "R3 R4 R11 write data/oe", bad_oe, 0);
        end else begin
            chk(lead == int'(cfg[25:24]) && bad_pre == 0, "R5 read lead", lead, int'(cfg[25:24]));
            chk(low == e_low(cfg, 1'b0), "R6 read low length (R2 fields)", low, e_low(cfg, 1'b0));
            chk(hold == e_hold(cfg, 1'b0), "R6 read hold", hold, e_hold(cfg, 1'b0));
            chk(bad_oe == 0, "R5 R11 oe off on read", bad_oe, 0);
            chk(rv_cnt == 1 && rv_good == 1, "R7 read capture", rv_good, 1);
        end
        chk(tail == e_tail(cfg, wr), "R8 recovery length", tail, e_tail(cfg, wr));
        chk(bad_busy == 0, "R9 busy masked during op", bad_busy, 0);
        nand_rdy_bsy = 1'b0; #1;
        chk(busy == 1'b1, "R9 busy follows pin", busy, 1);
        nand_rdy_bsy = 1'b1; #1;
        chk(busy == 1'b0, "R9 ready follows pin", busy, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe, "R1 strobes idle in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !rd_valid && nand_ce_n && !nand_dq_oe, "R1 after reset", req_ready, 1);
        nand_rdy_bsy = 1'b0; #1;
        chk(!busy, "R1 R9 busy unarmed after reset", busy, 0);
        nand_rdy_bsy = 1'b1;
        // Directed corners.
        run_op(1'b1, 32'h0000_0000, 8'hA5);
        run_op(1'b0, 32'h0000_0000, 8'h3C);
        run_op(1'b1, 32'hFFFF_FFFF, 8'h5A);
        run_op(1'b0, 32'hFFFF_FFFF, 8'hC3);
        run_op(1'b1, 32'h0000_0029, 8'h11);   // WH < WL: clamp
        run_op(1'b0, 32'h0200_2900, 8'h22);   // RH < RL: clamp, lead 2
        run_op(1'b0, 32'h0107_1200, 8'h33);   // turnaround dominates
        run_op(1'b1, 32'h00F8_0010, 8'h44);   // busy ignore dominates
        run_op(1'b0, 32'h03F8_0000, 8'h55);
        for (int i = 0; i < 40; i++)
            run_op(1'($urandom), $urandom, 8'($urandom));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule